// File: doc/BRIEF.md
# Glyph to Bitmap Blit Engine

This block draws one character glyph into a word-addressed destination bitmap. The caller supplies a font base address, a character code, the address of the first destination scan line, a bit offset inside the first destination word, and the stride in words between scan lines. On a start pulse the engine locates the glyph through the font's index word and reads the glyph header. It steps the destination past the blank lines at the top. Then, for every glyph row, it reads the row word, aligns it to the bit offset and ORs it into one or two destination words by read-modify-write.

All memory traffic goes through a single 16-bit read/write port with a valid/ready request handshake and a valid-qualified read response. Only one request is ever in flight. When the glyph is finished the engine fetches the glyph's width word, presents it shifted right by one together with a flag taken from its low bit, and pulses `done` for one clock.

Top module: `glyph_blit`

## Requirements
- R1: The index word is read at address P = font_base + char_code. The glyph's width word W lives at X = P + (index word) + 1, with all address sums taken modulo 2^AW.
- R2: The header word is read at X + 1. Bits 15:8 give the number of blank lines to skip, and bits 7:0 give the row count N. Row words sit at X − N up to X − 1 and are drawn in ascending address order, top row first.
- R3: The first drawn row goes to destination address D = dst_addr + skip × stride. Each later row goes to the previous row's address plus stride.
- R4: Let S = 15 − bit_off and V = {row, 16'h0000} >> S, a 32-bit value. V[31:16] is ORed into the word at D, and V[15:0] is ORed into the word at D + 1. Every destination bit outside those ORs keeps its old value.
- R5: When bit_off = 15, each row modifies only the word at D. The engine issues no access to D + 1, so a glyph of N rows causes exactly N writes. For any other offset it causes 2N writes.
- R6: A row count of zero causes no destination reads or writes. The width word is still returned.
- R7: At completion, width_out = W >> 1 and no_ext = W[0]. Both hold their values until the next completion.
- R8: `done` is high for exactly one clock per accepted job. `busy` is high from the clock after an accepted start until the clock in which `done` rises, and it is low while `done` is high.
- R9: A start pulse that arrives while busy is ignored. It causes no extra `done` and no memory change, and the running job finishes with the parameters it latched.
- R10: A request stays valid with a stable address, direction and write data until ready is sampled high. No new request is issued while a read response is still awaited.
- R11: While reset is asserted and after it is released, busy, done and mem_req_valid are low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a job; sampled only while idle |
| font_base | input | AW | Base address of the font index table |
| char_code | input | CW | Character code, added to font_base |
| dst_addr | input | AW | Address of the first destination scan line word |
| bit_off | input | log2(DW) | Bit position in the first word where the row's top bit lands |
| stride | input | AW | Words per destination scan line |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-clock completion pulse |
| width_out | output | DW | Width word shifted right by one |
| no_ext | output | 1 | Low bit of the width word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request word address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | DW | Read data |

## Verification
The bench builds the engine with AW = 12, DW = 16 and CW = 8. With a 12-bit address, the bench memory model covers the whole address space, so every address the engine can form maps to real storage. This lets a job whose index lookup and destination rows wrap past the top of memory be checked against the modulo-2^AW rules. It also exposes any write that strays outside the expected words. The memory model stalls ready and varies the read latency between one and three clocks, so the request-hold and single-outstanding rules are exercised under back-pressure.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IDX,
    ST_HDR,
    ST_SKIP,
    ST_ROW,
    ST_D0R,
    ST_D0W,
    ST_D1R,
    ST_D1W,
    ST_ADV,
    ST_WID
  } blit_st_e;

  typedef enum logic [1:0] {
    MIF_IDLE,
    MIF_REQ,
    MIF_WAIT
  } mif_st_e;

endpackage

// File: rtl/blit_rst_sync.sv
module blit_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/blit_mem_if.sv
module blit_mem_if #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          xfer_done,
  output logic [DW-1:0] xfer_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  import blit_pkg::*;

  mif_st_e       st_q, st_d;
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          cap_en;

  // Next state: a request is latched only from idle, held until accepted,
  // and a read then waits for its single response.
  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    unique case (st_q)
      MIF_IDLE: begin
        if (go) begin
          st_d   = MIF_REQ;
          cap_en = 1'b1;
        end
      end
      MIF_REQ: begin
        if (mem_req_ready) begin
          st_d = we_q ? MIF_IDLE : MIF_WAIT;
        end
      end
      MIF_WAIT: begin
        if (mem_rsp_valid) begin
          st_d = MIF_IDLE;
        end
      end
      default: st_d = MIF_IDLE;
    endcase
    we_d    = cap_en ? go_we    : we_q;
    addr_d  = cap_en ? go_addr  : addr_q;
    wdata_d = cap_en ? go_wdata : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= MIF_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign mem_req_valid = (st_q == MIF_REQ);
  assign mem_req_we    = we_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  assign xfer_done  = ((st_q == MIF_REQ) && mem_req_ready && we_q) ||
                      ((st_q == MIF_WAIT) && mem_rsp_valid);
  assign xfer_rdata = mem_rsp_rdata;

  // R10: an unaccepted request keeps address, direction and data
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) &&
       $stable(mem_req_wdata)));

  // R10: a response only comes back while one read is awaited
  a_r10_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (st_q == MIF_WAIT));

  // R10: no new request goes out while a read response is awaited
  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MIF_WAIT) && !mem_rsp_valid) |=> !mem_req_valid);

endmodule

// File: rtl/glyph_merge.sv
module glyph_merge #(
  parameter int DW = 16,
  localparam int OW = $clog2(DW)
) (
  input  logic [DW-1:0] row,
  input  logic [OW-1:0] lshift,
  output logic [DW-1:0] first_bits,
  output logic [DW-1:0] spill_bits
);

  logic [2*DW-1:0] wide;

  // Row sits at the top of a double word and moves right by lshift;
  // its upper half lands in the first word, the remainder spills over.
  always_comb begin
    wide = {row, {DW{1'b0}}} >> lshift;
  end

  genvar b;
  generate
    for (b = 0; b < DW; b++) begin : g_lane
      assign first_bits[b] = wide[DW + b];
      assign spill_bits[b] = wide[b];
    end
  endgenerate

endmodule

// File: rtl/glyph_blit.sv
module glyph_blit #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          font_base,
  input  logic [CW-1:0]          char_code,
  input  logic [AW-1:0]          dst_addr,
  input  logic [$clog2(DW)-1:0]  bit_off,
  input  logic [AW-1:0]          stride,
  output logic                   busy,
  output logic                   done,
  output logic [DW-1:0]          width_out,
  output logic                   no_ext,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_req_we,
  output logic [AW-1:0]          mem_req_addr,
  output logic [DW-1:0]          mem_req_wdata,
  input  logic                   mem_rsp_valid,
  input  logic [DW-1:0]          mem_rsp_rdata
);
  import blit_pkg::*;

  localparam int OW = $clog2(DW);
  localparam int HW = DW / 2;
  localparam logic [OW-1:0] OFF_ONE_WORD = OW'(DW - 1);

  logic rst_q_n;

  blit_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  // Job state
  blit_st_e      st_q, st_d;
  logic [AW-1:0] base_q, base_d;      // font_base + char_code
  logic [AW-1:0] stride_q, stride_d;
  logic [OW-1:0] off_q, off_d;
  logic [AW-1:0] xw_q, xw_d;          // width word address
  logic [AW-1:0] dst_q, dst_d;        // current destination line
  logic [AW-1:0] rptr_q, rptr_d;      // next row word address
  logic [HW-1:0] skip_q, skip_d;
  logic [HW-1:0] rows_q, rows_d;
  logic [DW-1:0] row_q, row_d;
  logic [DW-1:0] wbuf_q, wbuf_d;
  logic [DW-1:0] wid_q, wid_d;
  logic          noext_q, noext_d;
  logic          done_q, done_d;
  logic          pend_q, pend_d;

  // Memory command path
  logic          acc_state;
  logic          cmd_go;
  logic          cmd_we;
  logic [AW-1:0] cmd_addr;
  logic          cmd_done;
  logic [DW-1:0] cmd_rdata;

  logic [DW-1:0] first_bits, spill_bits;
  logic [OW-1:0] lshift;

  assign lshift = OFF_ONE_WORD - off_q;

  glyph_merge #(.DW(DW)) u_merge (
    .row        (row_q),
    .lshift     (lshift),
    .first_bits (first_bits),
    .spill_bits (spill_bits)
  );

  blit_mem_if #(.AW(AW), .DW(DW)) u_mif (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .go            (cmd_go),
    .go_we         (cmd_we),
    .go_addr       (cmd_addr),
    .go_wdata      (wbuf_q),
    .xfer_done     (cmd_done),
    .xfer_rdata    (cmd_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata)
  );

  // Which states own a memory access, and where it points
  always_comb begin
    acc_state = 1'b0;
    cmd_we    = 1'b0;
    cmd_addr  = '0;
    unique case (st_q)
      ST_IDX: begin acc_state = 1'b1; cmd_addr = base_q;              end
      ST_HDR: begin acc_state = 1'b1; cmd_addr = xw_q + AW'(1);       end
      ST_ROW: begin acc_state = 1'b1; cmd_addr = rptr_q;              end
      ST_D0R: begin acc_state = 1'b1; cmd_addr = dst_q;               end
      ST_D0W: begin acc_state = 1'b1; cmd_addr = dst_q; cmd_we = 1'b1; end
      ST_D1R: begin acc_state = 1'b1; cmd_addr = dst_q + AW'(1);      end
      ST_D1W: begin acc_state = 1'b1; cmd_addr = dst_q + AW'(1); cmd_we = 1'b1; end
      ST_WID: begin acc_state = 1'b1; cmd_addr = xw_q;                end
      default: begin end
    endcase
  end

  assign cmd_go = acc_state && !pend_q;

  // Sequencer next state
  always_comb begin
    st_d     = st_q;
    base_d   = base_q;
    stride_d = stride_q;
    off_d    = off_q;
    xw_d     = xw_q;
    dst_d    = dst_q;
    rptr_d   = rptr_q;
    skip_d   = skip_q;
    rows_d   = rows_q;
    row_d    = row_q;
    wbuf_d   = wbuf_q;
    wid_d    = wid_q;
    noext_d  = noext_q;
    done_d   = 1'b0;
    pend_d   = cmd_go ? 1'b1 : (cmd_done ? 1'b0 : pend_q);

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          base_d   = font_base + AW'(char_code);
          stride_d = stride;
          off_d    = bit_off;
          dst_d    = dst_addr;
          st_d     = ST_IDX;
        end
      end
      ST_IDX: begin
        if (cmd_done) begin
          xw_d = base_q + AW'(cmd_rdata) + AW'(1);
          st_d = ST_HDR;
        end
      end
      ST_HDR: begin
        if (cmd_done) begin
          skip_d = cmd_rdata[DW-1:HW];
          rows_d = cmd_rdata[HW-1:0];
          rptr_d = xw_q - AW'(cmd_rdata[HW-1:0]);
          st_d   = ST_SKIP;
        end
      end
      ST_SKIP: begin
        if (skip_q != '0) begin
          dst_d  = dst_q + stride_q;
          skip_d = skip_q - HW'(1);
        end else if (rows_q == '0) begin
          st_d = ST_WID;
        end else begin
          st_d = ST_ROW;
        end
      end
      ST_ROW: begin
        if (cmd_done) begin
          row_d  = cmd_rdata;
          rptr_d = rptr_q + AW'(1);
          st_d   = ST_D0R;
        end
      end
      ST_D0R: begin
        if (cmd_done) begin
          wbuf_d = cmd_rdata | first_bits;
          st_d   = ST_D0W;
        end
      end
      ST_D0W: begin
        if (cmd_done) begin
          st_d = (off_q == OFF_ONE_WORD) ? ST_ADV : ST_D1R;
        end
      end
      ST_D1R: begin
        if (cmd_done) begin
          wbuf_d = cmd_rdata | spill_bits;
          st_d   = ST_D1W;
        end
      end
      ST_D1W: begin
        if (cmd_done) begin
          st_d = ST_ADV;
        end
      end
      ST_ADV: begin
        dst_d  = dst_q + stride_q;
        rows_d = rows_q - HW'(1);
        st_d   = (rows_q == HW'(1)) ? ST_WID : ST_ROW;
      end
      ST_WID: begin
        if (cmd_done) begin
          wid_d   = cmd_rdata >> 1;
          noext_d = cmd_rdata[0];
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      stride_q <= '0;
      off_q    <= '0;
      xw_q     <= '0;
      dst_q    <= '0;
      rptr_q   <= '0;
      skip_q   <= '0;
      rows_q   <= '0;
      row_q    <= '0;
      wbuf_q   <= '0;
      wid_q    <= '0;
      noext_q  <= 1'b0;
      done_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      base_q   <= base_d;
      stride_q <= stride_d;
      off_q    <= off_d;
      xw_q     <= xw_d;
      dst_q    <= dst_d;
      rptr_q   <= rptr_d;
      skip_q   <= skip_d;
      rows_q   <= rows_d;
      row_q    <= row_d;
      wbuf_q   <= wbuf_d;
      wid_q    <= wid_d;
      noext_q  <= noext_d;
      done_q   <= done_d;
      pend_q   <= pend_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign width_out = wid_q;
  assign no_ext    = noext_q;

  // R8: completion is a single-clock pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done);

  // R8: an idle start makes the block busy on the next clock
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && start) |=> busy);

  // R9: latched job parameters do not move while a job runs
  a_r9_params_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && $past(busy)) |-> ($stable(off_q) && $stable(stride_q) && $stable(base_q)));

  // R7: results change only together with a completion pulse
  a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_q_n)
    !done |-> ($stable(width_out) && $stable(no_ext)));

  // R5: a full-width offset never reaches the second destination word
  a_r5_one_word: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_req_valid && busy && (off_q == OFF_ONE_WORD) && mem_req_we) |->
      (mem_req_addr == dst_q));

  // R6: an empty glyph goes straight from the skip phase to the width read
  a_r6_empty_glyph: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q == ST_SKIP && skip_q == '0 && rows_q == '0) |=> (st_q == ST_WID));

endmodule

// File: tb/glyph_blit_tb.sv
`timescale 1ns/1ps
module glyph_blit_tb;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int MEMW = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] font_base;
  logic [CW-1:0] char_code;
  logic [AW-1:0] dst_addr;
  logic [3:0]    bit_off;
  logic [AW-1:0] stride;
  logic          busy, done, no_ext;
  logic [DW-1:0] width_out;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;

  glyph_blit #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .font_base     (font_base),
    .char_code     (char_code),
    .dst_addr      (dst_addr),
    .bit_off       (bit_off),
    .stride        (stride),
    .busy          (busy),
    .done          (done),
    .width_out     (width_out),
    .no_ext        (no_ext),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int n_done   = 0;
  int n_wr     = 0;
  int n_viol   = 0;
  bit finished = 0;

  logic [DW-1:0] mem     [MEMW];
  logic [DW-1:0] exp_mem [MEMW];
  logic [DW:0]   sb_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Memory model: random ready, 1..3 clock read latency
  logic [15:0]   lfsr;
  int            rd_wait;
  logic [DW-1:0] rd_buf;
  logic          held_v;
  logic [AW-1:0] held_addr;

  always @(negedge clk) begin
    mem_req_ready <= (lfsr[3:2] != 2'b00);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr          <= 16'hACE1;
      rd_wait       <= 0;
      rd_buf        <= '0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      held_v        <= 1'b0;
      held_addr     <= '0;
    end else begin
      lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_rsp_valid <= 1'b0;
      if (rd_wait > 0) begin
        if (rd_wait == 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= rd_buf;
        end
        rd_wait <= rd_wait - 1;
      end
      if (held_v && mem_req_valid && (mem_req_addr != held_addr)) n_viol <= n_viol + 1;
      held_v    <= mem_req_valid && !mem_req_ready;
      held_addr <= mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (rd_wait != 0 || mem_rsp_valid) n_viol <= n_viol + 1;
        if (mem_req_we) begin
          mem[mem_req_addr] <= mem_req_wdata;
          n_wr <= n_wr + 1;
        end else begin
          rd_buf  <= mem[mem_req_addr];
          rd_wait <= 1 + ((lfsr[5:4] == 2'b11) ? 0 : int'(lfsr[5:4]));
        end
      end
    end
  end

  // Monitor: pops the scoreboard on every completion
  bit chk_done_low = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_done_low) begin
        chk("R8 done low after pulse", {31'd0, done}, 32'd0);
        chk_done_low = 0;
      end
      if (done) begin
        n_done++;
        chk("R8 busy low with done", {31'd0, busy}, 32'd0);
        chk_done_low = 1;
        if (sb_q.size() == 0) begin
          chk("R9 unexpected completion", 32'd1, 32'd0);
        end else begin
          logic [DW:0] e;
          e = sb_q.pop_front();
          chk("R7 width_out", {16'd0, width_out}, {16'd0, e[DW-1:0]});
          chk("R7 no_ext", {31'd0, no_ext}, {31'd0, e[DW]});
        end
      end
    end
  end

  // Glyph placement in memory: index word, rows, width word, header
  task automatic place_glyph(input logic [AW-1:0] fb, input logic [CW-1:0] ch,
                             input logic [AW-1:0] xw, input logic [7:0] hd,
                             input logic [7:0] xh, input logic [DW-1:0] w,
                             input logic [DW-1:0] seed);
    logic [AW-1:0] p0;
    p0 = fb + AW'(ch);
    mem[p0] = DW'(AW'(xw - p0 - AW'(1)));
    mem[xw] = w;
    mem[AW'(xw + AW'(1))] = {hd, xh};
    for (int r = 0; r < int'(xh); r++) begin
      mem[AW'(xw - AW'(xh) + AW'(r))] = seed ^ DW'(r * 16'h1357) ^ {DW'(r), 8'h00};
    end
  endtask

  // Driver: computes the expected result from the requirements
  task automatic run_job(input logic [AW-1:0] fb, input logic [CW-1:0] ch,
                         input logic [AW-1:0] dst, input logic [3:0] off,
                         input logic [AW-1:0] strd, input bit intrude,
                         input string tag);
    logic [AW-1:0] p0, xw, d;
    logic [DW-1:0] hdr, row, w;
    logic [31:0]   comb;
    int hd, xh, wr0, exp_wr, target, mism;
    for (int i = 0; i < MEMW; i++) exp_mem[i] = mem[i];
    p0  = fb + AW'(ch);                        // R1
    xw  = p0 + AW'(mem[p0]) + AW'(1);
    hdr = mem[AW'(xw + AW'(1))];               // R2
    hd  = int'(hdr[15:8]);
    xh  = int'(hdr[7:0]);
    d   = dst;
    for (int s = 0; s < hd; s++) d = d + strd; // R3
    for (int r = 0; r < xh; r++) begin
      row  = mem[AW'(xw - AW'(xh) + AW'(r))];
      comb = {row, 16'h0000} >> (15 - int'(off)); // R4
      exp_mem[d] = exp_mem[d] | comb[31:16];
      if (off != 4'hF) exp_mem[AW'(d + AW'(1))] = exp_mem[AW'(d + AW'(1))] | comb[15:0];
      d = d + strd;
    end
    w = mem[xw];
    exp_wr = xh * ((off == 4'hF) ? 1 : 2);
    sb_q.push_back({w[0], 1'b0, w[15:1]});
    wr0    = n_wr;
    target = n_done + 1;
    @(negedge clk);
    font_base = fb; char_code = ch; dst_addr = dst; bit_off = off; stride = strd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (6) @(negedge clk);
      chk({"R9 busy during job ", tag}, {31'd0, busy}, 32'd1);
      font_base = fb + AW'(3); dst_addr = dst + AW'(16); bit_off = off ^ 4'h5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (n_done < target && !finished) @(negedge clk);
    repeat (4) @(negedge clk);
    mism = 0;
    for (int i = 0; i < MEMW; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk({"R3/R4 memory image ", tag}, mism, 0);
    chk({"R5/R6 write count ", tag}, n_wr - wr0, exp_wr);
    chk({"R9 single completion ", tag}, n_done, target);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    font_base = '0; char_code = '0; dst_addr = '0; bit_off = '0; stride = '0;
    for (int i = 0; i < MEMW; i++) mem[i] = (i >= 12'h800 && i < 12'hF00) ? 16'h0102 : 16'h0000;
    for (int i = 12'hFF0; i < MEMW; i++) mem[i] = 16'h4000;
    place_glyph(12'h100, 8'd5, 12'h200, 8'd2, 8'd3, 16'h0013, 16'hF00F);
    place_glyph(12'h100, 8'd6, 12'h240, 8'd0, 8'd4, 16'h0010, 16'h8001);
    place_glyph(12'h100, 8'd7, 12'h280, 8'd5, 8'd2, 16'h0027, 16'hA5C3);
    place_glyph(12'h100, 8'd8, 12'h2C0, 8'd3, 8'd0, 16'h0104, 16'h0000);
    place_glyph(12'hFF0, 8'h20, 12'h300, 8'd1, 8'd2, 16'h0055, 16'hFFFF); // index at 0x010
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", {31'd0, busy}, 32'd0);
    chk("R11 done in reset", {31'd0, done}, 32'd0);
    chk("R11 req in reset", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 idle after reset", {30'd0, busy, mem_req_valid}, 32'd0);

    run_job(12'h100, 8'd5, 12'h800, 4'hF, 12'd4, 1'b0, "R5 one word skip2");
    run_job(12'h100, 8'd6, 12'h900, 4'h0, 12'd3, 1'b0, "R4 offset0");
    run_job(12'h100, 8'd7, 12'hA00, 4'h7, 12'd5, 1'b0, "R2 offset7 skip5");
    run_job(12'h100, 8'd8, 12'hB00, 4'h3, 12'd2, 1'b0, "R6 zero rows");
    run_job(12'h100, 8'd6, 12'hC00, 4'h9, 12'd6, 1'b1, "R9 start ignored");
    run_job(12'hFF0, 8'h20, 12'hFFE, 4'h4, 12'd1, 1'b0, "R1 address wrap");

    chk("R10 handshake violations", n_viol, 0);
    chk("R8 scoreboard drained", sb_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule